// File: doc/BRIEF.md
# Memory Controller Performance Counter Unit

This unit holds a small bank of event counters for a memory controller. A processor programs it through a plain register port: an address, a write enable, write data and registered read data. Each counter slot has a control word and a read-only count word. In the control word, software turns the slot on, zeroes it and picks the controller event strobe that the slot counts. The event strobes arrive as a vector of single-cycle pulses, indexed by event code.

Slot 0 counts clock cycles and nothing else, and it gates the whole unit. When slot 0 is turned off, every slot holds its value. When slot 0 wraps, every slot freezes and a level interrupt is raised. The interrupt stays high until software clears the overflow flag of slot 0. The other slots wrap silently and keep counting. The zeroing protocol differs between slot 0 and the others, so a driver can use one start sequence for all slots.

Top module: `mcperf_unit`

## Requirements
- R1: After reset every count reads 0, every slot is disabled and irq is low. The control word of slot 0 reads 0x00000000 and the control words of slots 1..3 read 0x00000002.
- R2: The control word of slot n is at address 4*n and its count is at 0x20+4*n. Read data is registered: it shows the addressed register as it stood just before the clock edge that samples the address. Unmapped addresses read 0, and writes to count addresses are ignored.
- R3: The control word has the overflow flag in bit 0, the clear bit in bit 1, the enable bit in bit 2 and the 8-bit event code in bits 31:24. All other bits read 0.
- R4: While slot 0 is enabled and its overflow flag is clear, slot 0 adds one on every clock. Its event code is stored and read back but has no effect on counting.
- R5: Slot n (1..3) adds one in each cycle in which it is enabled, the unit is running (slot 0 enabled with its overflow flag clear) and evt_strobe[code] is high. Code 0 and codes of NUM_EVT or above count nothing.
- R6: While slot 0 is disabled, all slots hold their counts. Enabling slot 0 again resumes counting.
- R7: When slot 0 steps from all ones, it becomes 0, sets its overflow flag and drives irq high after that edge. From the next cycle on, every slot is frozen. An event seen by another slot in the wrap cycle is still counted.
- R8: When slot 1..3 steps from all ones, it becomes 0, sets its own overflow flag and keeps counting. irq does not rise.
- R9: Overflow flags are sticky. Writing 0 to bit 0 clears the flag and writing 1 leaves it unchanged. irq follows the flag of slot 0. If a wrap and a clearing write fall on the same edge, the flag ends set.
- R10: Slot 0 is zeroed only by a write with bit 1 = 1 while its stored clear bit is 0. The clear bit reads back the value last written.
- R11: Slots 1..3 are zeroed by a write with bit 1 = 0, and their clear bit always reads 1. A write with bit 1 = 1 does not zero them.
- R12: A control write with the enable bit at 0 leaves the count unchanged. When a zeroing write and an increment fall on the same edge, the zeroing wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register byte address |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| evt_strobe | input | NUM_EVT | Event pulses, one bit per event code |
| irq | output | 1 | Level interrupt, high while the overflow flag of slot 0 is set |

## Verification
Two pairs of functions can fall on the same edge. The first is the wrap of slot 0 and a software write that clears its overflow flag. The second is a zeroing write to a slot and an event that slot would count. The bench uses a narrow 8-bit counter, zeroes slot 0 and derives the exact edge of the wrap from the cycle arithmetic. It then issues the clearing write on that edge and expects irq high and the flag read back as 1. In the same way it raises the selected strobe on the edge of a zeroing write and expects the slot to read 0 and not 1.

// File: rtl/mcperf_pkg.sv
package mcperf_pkg;
  localparam int REG_W     = 32;
  localparam int SEL_W     = 8;
  localparam int BIT_OVF   = 0;
  localparam int BIT_CLR   = 1;
  localparam int BIT_EN    = 2;
  localparam int SEL_LSB   = 24;
  localparam int CTRL_BASE = 'h00;
  localparam int CNT_BASE  = 'h20;

  // Build a control readback word from its fields; unused bits read 0.
  function automatic logic [REG_W-1:0] pack_ctrl(input logic [SEL_W-1:0] sel,
                                                 input logic en,
                                                 input logic clr,
                                                 input logic ovf);
    logic [REG_W-1:0] w;
    w = '0;
    w[SEL_LSB +: SEL_W] = sel;
    w[BIT_EN]  = en;
    w[BIT_CLR] = clr;
    w[BIT_OVF] = ovf;
    return w;
  endfunction
endpackage

// File: rtl/mcperf_evsel.sv
module mcperf_evsel
  import mcperf_pkg::*;
#(
  parameter int NUM_EVT = 64
) (
  input  logic [NUM_EVT-1:0] evt_strobe,
  input  logic [SEL_W-1:0]   sel,
  output logic               hit
);
  localparam int IDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

  logic in_range;
  logic [IDX_W-1:0] idx;

  always_comb begin
    // code 0 is the cycle code; it belongs to slot 0 only
    in_range = (32'(sel) < NUM_EVT) && (sel != '0);
    idx      = IDX_W'(sel);
    hit      = in_range && evt_strobe[idx];
  end
endmodule

// File: rtl/mcperf_counter.sv
module mcperf_counter
  import mcperf_pkg::*;
#(
  parameter int CTR_W    = 32,
  parameter bit IS_CYCLE = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_ovf,
  input  logic             wr_clr,
  input  logic             wr_enb,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic             run,
  input  logic             evt_hit,
  output logic [CTR_W-1:0] cnt_o,
  output logic             en_o,
  output logic             clr_o,
  output logic             ovf_o,
  output logic [SEL_W-1:0] sel_o
);
  localparam logic [CTR_W-1:0] CNT_MAX = '1;

  logic [CTR_W-1:0] cnt_q;
  logic             en_q;
  logic             ovf_q;
  logic [SEL_W-1:0] sel_q;
  logic             inc;
  logic             clr_hit;
  logic             wrap;

  generate
    if (IS_CYCLE) begin : g_edge_clear
      // zeroing needs a 0 stored in the clear bit, then a 1 written
      logic clr_q;
      always_ff @(posedge clk) begin
        if (rst)        clr_q <= 1'b0;
        else if (wr_en) clr_q <= wr_clr;
      end
      assign clr_hit = wr_en && wr_clr && !clr_q;
      assign clr_o   = clr_q;
    end else begin : g_level_clear
      // writing 0 zeroes the count; the bit is returned to 1 at once
      assign clr_hit = wr_en && !wr_clr;
      assign clr_o   = 1'b1;
    end
  endgenerate

  always_comb begin
    inc  = en_q && run && evt_hit;
    wrap = inc && !clr_hit && (cnt_q == CNT_MAX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
      ovf_q <= 1'b0;
      sel_q <= '0;
    end else begin
      if (clr_hit)  cnt_q <= '0;
      else if (inc) cnt_q <= cnt_q + 1'b1;
      if (wr_en) begin
        en_q  <= wr_enb;
        sel_q <= wr_sel;
      end
      if (wrap)                  ovf_q <= 1'b1;
      else if (wr_en && !wr_ovf) ovf_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign en_o  = en_q;
  assign ovf_o = ovf_q;
  assign sel_o = sel_q;

  AST_HOLD_WHEN_HALTED: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_en) |=> $stable(cnt_q)); // R6
  AST_STEP_OR_ZERO: assert property (@(posedge clk) disable iff (rst)
    !$stable(cnt_q) |-> ((cnt_q == CTR_W'($past(cnt_q) + 1'b1)) || (cnt_q == '0))); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !(wr_en && !wr_ovf)) |=> ovf_q); // R9
  AST_DISABLED_WRITE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_enb && !clr_hit && !inc) |=> $stable(cnt_q)); // R12
endmodule

// File: rtl/mcperf_regif.sv
module mcperf_regif
  import mcperf_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int CTR_W   = 32,
  parameter int ADDR_W  = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [ADDR_W-1:0]               reg_addr,
  input  logic                            reg_we,
  input  logic [NUM_CTR-1:0][REG_W-1:0]   ctrl_words,
  input  logic [NUM_CTR-1:0][CTR_W-1:0]   counts,
  output logic [NUM_CTR-1:0]              ctrl_wr,
  output logic [REG_W-1:0]                reg_rdata
);
  logic [REG_W-1:0] rd_d;

  always_comb begin
    ctrl_wr = '0;
    rd_d    = '0;
    for (int n = 0; n < NUM_CTR; n++) begin
      if (reg_addr == ADDR_W'(CTRL_BASE + 4 * n)) begin
        ctrl_wr[n] = reg_we;
        rd_d       = ctrl_words[n];
      end
      if (reg_addr == ADDR_W'(CNT_BASE + 4 * n))
        rd_d = REG_W'(counts[n]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_d;
  end

  AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctrl_wr)); // R2
endmodule

// File: rtl/mcperf_unit.sv
module mcperf_unit
  import mcperf_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int CTR_W   = 32,
  parameter int NUM_EVT = 64,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_we,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic [NUM_EVT-1:0] evt_strobe,
  output logic               irq
);
  localparam logic [CTR_W-1:0] CNT_MAX = '1;

  logic [NUM_CTR-1:0][REG_W-1:0] ctrl_words;
  logic [NUM_CTR-1:0][CTR_W-1:0] counts;
  logic [NUM_CTR-1:0]            ctrl_wr;
  logic [NUM_CTR-1:0]            en_v, clr_v, ovf_v, hit_v;
  logic [NUM_CTR-1:0][SEL_W-1:0] sel_v;
  logic                          run;

  // slot 0 gates the unit: enabled and not overflowed
  assign run = en_v[0] && !ovf_v[0];
  assign irq = ovf_v[0];

  mcperf_regif #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .ADDR_W(ADDR_W)) u_regif (
    .clk        (clk),
    .rst        (rst),
    .reg_addr   (reg_addr),
    .reg_we     (reg_we),
    .ctrl_words (ctrl_words),
    .counts     (counts),
    .ctrl_wr    (ctrl_wr),
    .reg_rdata  (reg_rdata)
  );

  generate
    for (genvar g = 0; g < NUM_CTR; g++) begin : g_slot
      if (g == 0) begin : g_cycle
        assign hit_v[g] = 1'b1;
      end else begin : g_event
        mcperf_evsel #(.NUM_EVT(NUM_EVT)) u_evsel (
          .evt_strobe (evt_strobe),
          .sel        (sel_v[g]),
          .hit        (hit_v[g])
        );
      end

      mcperf_counter #(.CTR_W(CTR_W), .IS_CYCLE(g == 0)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ctrl_wr[g]),
        .wr_ovf  (reg_wdata[BIT_OVF]),
        .wr_clr  (reg_wdata[BIT_CLR]),
        .wr_enb  (reg_wdata[BIT_EN]),
        .wr_sel  (reg_wdata[SEL_LSB +: SEL_W]),
        .run     (run),
        .evt_hit (hit_v[g]),
        .cnt_o   (counts[g]),
        .en_o    (en_v[g]),
        .clr_o   (clr_v[g]),
        .ovf_o   (ovf_v[g]),
        .sel_o   (sel_v[g])
      );

      assign ctrl_words[g] = pack_ctrl(sel_v[g], en_v[g], clr_v[g], ovf_v[g]);
    end
  endgenerate

  AST_IRQ_ONLY_ON_CYCLE_WRAP: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ((counts[0] == '0) && ($past(counts[0]) == CNT_MAX))); // R7
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (irq && !(ctrl_wr[0] && !reg_wdata[BIT_OVF])) |=> irq); // R9
endmodule

// File: tb/mcperf_unit_test.sv
module mcperf_unit_test;
  localparam int NUM_CTR = 4;
  localparam int CTR_W   = 8;
  localparam int NUM_EVT = 64;
  localparam int ADDR_W  = 8;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [ADDR_W-1:0]  reg_addr = '0;
  logic               reg_we = 1'b0;
  logic [31:0]        reg_wdata = '0;
  logic [31:0]        reg_rdata;
  logic [NUM_EVT-1:0] evt_strobe = '0;
  logic               irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  mcperf_unit #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .NUM_EVT(NUM_EVT), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .evt_strobe(evt_strobe), .irq(irq)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] ca(input int n); return 8'(4 * n); endfunction
  function automatic logic [7:0] na(input int n); return 8'(32 + 4 * n); endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // each call consumes exactly one rising edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a; reg_we = 1'b0;
    @(negedge clk);
    chk(tag, reg_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 / R3 reset state
    chk("R1 irq after reset", 32'(irq), 0);
    for (int n = 0; n < NUM_CTR; n++) begin
      rd(ca(n), (n == 0) ? 32'h0 : 32'h2, "R1 control reset");
      rd(na(n), 32'h0, "R1 count reset");
    end
    // R2 unmapped reads
    rd(8'h10, 32'h0, "R2 unmapped 0x10");
    rd(8'h40, 32'h0, "R2 unmapped 0x40");

    // configure slots 1..3 (bit1=1 does not zero them)
    wr(ca(1), 32'h0400_0006);
    wr(ca(2), 32'h0500_0006);
    wr(ca(3), 32'h0000_0006);
    rd(ca(1), 32'h0400_0006, "R3 control layout slot1");

    // R4 / R5 main counting; slot 0 code is irrelevant
    wr(ca(0), 32'h3700_0004);
    rd(ca(0), 32'h3700_0004, "R4 slot0 code stored");
    // rd above consumed one running edge
    for (int i = 0; i < 40; i++) begin
      evt_strobe = '0;
      evt_strobe[0] = 1'b1;
      evt_strobe[4] = (i % 3 == 0);
      evt_strobe[5] = (i % 2 == 0);
      @(negedge clk);
    end
    evt_strobe = '0;
    wr(ca(0), 32'h0);
    rd(na(0), 32'd42, "R4 cycle count");
    rd(na(1), 32'd14, "R5 code 0x04 count");
    rd(na(2), 32'd20, "R5 code 0x05 count");
    rd(na(3), 32'd0,  "R5 code 0 counts nothing");

    // R6 halted while slot 0 disabled
    evt_strobe[4] = 1'b1;
    idle(10);
    evt_strobe = '0;
    rd(na(1), 32'd14, "R6 hold while slot0 off");
    wr(ca(0), 32'h4);
    evt_strobe[4] = 1'b1;
    idle(5);
    evt_strobe = '0;
    wr(ca(0), 32'h0);
    rd(na(1), 32'd19, "R6 resume after enable");
    rd(na(0), 32'd48, "R12 disabling write keeps slot0 count");

    // R10 slot 0 zeroing sequence
    wr(ca(0), 32'h2);
    rd(na(0), 32'd0, "R10 0-then-1 zeroes slot0");
    rd(ca(0), 32'h2, "R10 clear bit readback");
    wr(ca(0), 32'h6);
    idle(9);
    wr(ca(0), 32'h2);
    rd(na(0), 32'd10, "R10 repeated 1 does not zero");
    wr(ca(0), 32'h0);
    wr(ca(0), 32'h2);
    rd(na(0), 32'd0, "R10 zeroed after new 0-then-1");

    // R11 / R12 other slots
    wr(ca(1), 32'h0400_0002);
    rd(na(1), 32'd19, "R11 bit1=1 keeps count");
    rd(ca(1), 32'h0400_0002, "R12 disable write readback");
    wr(ca(1), 32'h0400_0000);
    rd(na(1), 32'd0, "R11 bit1=0 zeroes count");
    rd(ca(1), 32'h0400_0002, "R11 clear bit reads 1");

    // R2 count registers are read-only
    wr(na(2), 32'hFFFF_FFFF);
    rd(na(2), 32'd20, "R2 count write ignored");

    // R8 wrap of slot 2, out-of-range code on slot 3
    wr(ca(3), 32'h8000_0006);
    wr(ca(0), 32'h4);
    evt_strobe = '1;
    idle(240);
    evt_strobe = '0;
    wr(ca(0), 32'h0);
    chk("R8 no irq on slot2 wrap", 32'(irq), 0);
    rd(na(2), 32'd4, "R8 slot2 wrapped");
    rd(ca(2), 32'h0500_0007, "R8 slot2 overflow flag");
    rd(na(3), 32'd0, "R5 code >= NUM_EVT counts nothing");
    rd(na(0), 32'd241, "R4 cycle count before wrap");
    wr(ca(2), 32'h0500_0006);
    rd(ca(2), 32'h0500_0006, "R9 flag cleared by writing 0");

    // R7 wrap of slot 0
    wr(ca(1), 32'h0400_0004);
    wr(ca(0), 32'h0);
    wr(ca(0), 32'h6);
    idle(254);
    evt_strobe[4] = 1'b1;
    idle(3);
    evt_strobe = '0;
    chk("R7 irq after slot0 wrap", 32'(irq), 1);
    rd(na(0), 32'd0, "R7 slot0 wrapped to 0");
    rd(na(1), 32'd2, "R7 wrap-cycle event counted then frozen");
    rd(ca(0), 32'h7, "R7 slot0 overflow flag");
    idle(20);
    rd(na(0), 32'd0, "R7 slot0 stays frozen");

    // R9 sticky flag and irq release
    wr(ca(0), 32'h5);
    chk("R9 writing 1 keeps irq", 32'(irq), 1);
    rd(ca(0), 32'h5, "R9 flag kept");
    wr(ca(0), 32'h4);
    chk("R9 irq released", 32'(irq), 0);
    idle(255);
    wr(ca(0), 32'h4);
    chk("R9 wrap beats clearing write irq", 32'(irq), 1);
    rd(ca(0), 32'h5, "R9 wrap beats clearing write flag");
    rd(na(0), 32'd0, "R9 slot0 wrapped at collision");

    // R12 zeroing wins over same-edge increment
    wr(ca(0), 32'h4);
    evt_strobe[4] = 1'b1;
    wr(ca(1), 32'h0400_0004);
    evt_strobe = '0;
    wr(ca(0), 32'h0);
    rd(na(1), 32'd0, "R12 zeroing beats increment");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule